// File: doc/BRIEF.md
# Multi-Cycle-Path Data Bus Synchronizer

This block carries a multi-bit word from a source clock domain into an unrelated destination clock domain. The source marks each new word with a strobe that lasts one source cycle. That strobe flips a level toggle, and the word is held in a source register. Only the toggle crosses into the destination domain, through a chain of flip-flops. On the destination side an edge on the synchronized toggle makes a one-cycle load. The load captures the held source word into the destination output register, and a one-cycle output valid is raised in the cycle the new word first appears.

Nothing signals back to the source, so the source is responsible for pacing. After each strobe it must leave at least two destination periods plus the synchronizer latency before the next strobe. The block therefore suits low-rate transfers such as configuration words or occasional status. Each domain has its own active-low asynchronous reset.

Top module: `mcp_bus_sync`

## Requirements
- R1: While either reset is asserted and after it is released with no strobe, `dst_valid_o` is 0 and `dst_data_o` is all zeros.
- R2: Each source strobe produces exactly one `dst_valid_o` pulse, and that pulse is exactly one destination cycle long.
- R3: The word shown on `dst_data_o` with each valid pulse equals the word on `src_data_i` at the source edge where `src_valid_i` was high, and words arrive in strobe order.
- R4: Any bit pattern is carried unchanged, including all zeros, all ones and alternating bits.
- R5: `dst_valid_o` rises no fewer than 2 and no more than SYNC_STAGES+2 destination clock edges after the source edge that captured the strobe.
- R6: `dst_data_o` changes only in a cycle where `dst_valid_o` is high, and it holds between transfers.
- R7: Changing `src_data_i` while `src_valid_i` is low does not affect the word that is delivered.
- R8: With `src_valid_i` held low, `dst_valid_o` stays low and no load occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk_i | input | 1 | Source domain clock |
| src_rst_ni | input | 1 | Source domain asynchronous reset, active low |
| src_data_i | input | DATA_W | Word to transfer |
| src_valid_i | input | 1 | One-cycle strobe marking a new word |
| dst_clk_i | input | 1 | Destination domain clock |
| dst_rst_ni | input | 1 | Destination domain asynchronous reset, active low |
| dst_data_o | output | DATA_W | Captured word, held between transfers |
| dst_valid_o | output | 1 | One-cycle pulse when a new word appears |

## Verification
The bench changes the source bus to the inverse of each word right after its strobe. A design that sampled the live bus instead of the held register would then deliver corrupted words. The source and destination clocks are unrelated, and the gaps between strobes are random but legal. This exposes a registered edge detect, which adds a cycle and breaks the latency bound, and a stuck or doubled load, which shows up as a missing, repeated or two-cycle valid. A long idle stretch after reset catches any load caused by reset values. All-zero, all-one and alternating words catch data bits that are dropped or tied.

// File: rtl/mcp_sync_pkg.sv
package mcp_sync_pkg;
  localparam int unsigned DEF_DATA_W      = 32;
  localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/mcp_src_side.sv
module mcp_src_side #(
  parameter int unsigned DATA_W = mcp_sync_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              toggle_o,
  output logic [DATA_W-1:0] data_o
);
  logic              toggle_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      toggle_q <= 1'b0;
      data_q   <= '0;
    end else begin
      toggle_q <= toggle_q ^ valid_i;
      if (valid_i) data_q <= data_i;
    end
  end

  assign toggle_o = toggle_q;
  assign data_o   = data_q;

  // R7
  held_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  // R2
  strobe_flips_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (toggle_o != $past(toggle_o)));
  // R8
  idle_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(toggle_o));
endmodule

// File: rtl/mcp_bit_sync.sv
module mcp_bit_sync #(
  parameter int unsigned STAGES = mcp_sync_pkg::DEF_SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mcp_dst_side.sv
module mcp_dst_side #(
  parameter int unsigned DATA_W = mcp_sync_pkg::DEF_DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tog_sync_i,
  input  logic [DATA_W-1:0] src_word_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o,
  output logic              load_o
);
  logic              tog_dly_q;
  logic              valid_q;
  logic [DATA_W-1:0] data_q;
  logic              load;

  // combinational edge detect: no extra latency before capture
  assign load = tog_sync_i ^ tog_dly_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_dly_q <= 1'b0;
      valid_q   <= 1'b0;
      data_q    <= '0;
    end else begin
      tog_dly_q <= tog_sync_i;
      valid_q   <= load;
      if (load) data_q <= src_word_i;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
  assign load_o  = load;

  // R2
  single_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);
  // R2
  single_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R6
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

// File: rtl/mcp_bus_sync.sv
module mcp_bus_sync #(
  parameter int unsigned DATA_W      = mcp_sync_pkg::DEF_DATA_W,
  parameter int unsigned SYNC_STAGES = mcp_sync_pkg::DEF_SYNC_STAGES
) (
  input  logic              src_clk_i,
  input  logic              src_rst_ni,
  input  logic [DATA_W-1:0] src_data_i,
  input  logic              src_valid_i,
  input  logic              dst_clk_i,
  input  logic              dst_rst_ni,
  output logic [DATA_W-1:0] dst_data_o,
  output logic              dst_valid_o
);
  logic              src_toggle;
  logic [DATA_W-1:0] src_word;
  logic              dst_toggle;
  logic              dst_load;

  mcp_src_side #(.DATA_W(DATA_W)) u_src (
    .clk_i   (src_clk_i),
    .rst_ni  (src_rst_ni),
    .data_i  (src_data_i),
    .valid_i (src_valid_i),
    .toggle_o(src_toggle),
    .data_o  (src_word)
  );

  mcp_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (dst_clk_i),
    .rst_ni(dst_rst_ni),
    .d_i   (src_toggle),
    .q_o   (dst_toggle)
  );

  // src_word is stable across the load by the pacing rule; only the toggle is synchronized
  mcp_dst_side #(.DATA_W(DATA_W)) u_dst (
    .clk_i     (dst_clk_i),
    .rst_ni    (dst_rst_ni),
    .tog_sync_i(dst_toggle),
    .src_word_i(src_word),
    .data_o    (dst_data_o),
    .valid_o   (dst_valid_o),
    .load_o    (dst_load)
  );

  // R8
  no_load_at_idle_chk: assert property (@(posedge dst_clk_i) disable iff (!dst_rst_ni)
    $stable(dst_toggle) |-> !dst_load);
endmodule

// File: tb/mcp_bus_sync_bench.sv
module mcp_bus_sync_bench;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SYNC_STAGES = 2;
  localparam time DST_HALF = 2.5ns;
  localparam time SRC_HALF = 3.5ns;

  logic              src_clk = 1'b0;
  logic              dst_clk = 1'b0;
  logic              src_rst_n = 1'b0;
  logic              dst_rst_n = 1'b0;
  logic [DATA_W-1:0] src_data = '0;
  logic              src_valid = 1'b0;
  logic [DATA_W-1:0] dst_data;
  logic              dst_valid;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int got = 0;
  logic [DATA_W-1:0] exp_q[$];
  time               t_q[$];
  logic              prev_valid = 1'b0;
  logic [DATA_W-1:0] last_data = '0;
  logic              mon_on = 1'b0;
  logic              done = 1'b0;

  always #(SRC_HALF) src_clk = ~src_clk;
  always #(DST_HALF) dst_clk = ~dst_clk;

  mcp_bus_sync #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_mcp_bus_sync (
    .src_clk_i  (src_clk),
    .src_rst_ni (src_rst_n),
    .src_data_i (src_data),
    .src_valid_i(src_valid),
    .dst_clk_i  (dst_clk),
    .dst_rst_ni (dst_rst_n),
    .dst_data_o (dst_data),
    .dst_valid_o(dst_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic send(input logic [DATA_W-1:0] w, input int gap);
    @(negedge src_clk);
    src_data  = w;
    src_valid = 1'b1;
    @(posedge src_clk);
    exp_q.push_back(w);
    t_q.push_back($time);
    sent++;
    @(negedge src_clk);
    src_valid = 1'b0;
    src_data  = ~w; // R7: live bus changes while held word is in flight
    for (int i = 0; i < gap; i++) @(negedge src_clk);
  endtask

  // monitor / scoreboard
  always @(negedge dst_clk) begin
    if (mon_on) begin
      if (dst_valid) begin
        got++;
        // R2: one-cycle pulse
        chk(!prev_valid, "R2 single-cycle valid", {31'b0, prev_valid}, '0);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected extra transfer", dst_data, '0);
        end else begin
          logic [DATA_W-1:0] e;
          time t0, dt;
          e  = exp_q.pop_front();
          t0 = t_q.pop_front();
          dt = $time - t0;
          // R3 / R4 / R7
          chk(dst_data == e, "R3 word and order", dst_data, e);
          // R5: between 2 and SYNC_STAGES+2 dst edges, sampled half a period later
          chk(dt >= 10ns && dt <= (SYNC_STAGES + 2) * 5ns + 2.5ns, "R5 latency",
              DATA_W'(dt / 1ps), DATA_W'(((SYNC_STAGES + 2) * 5ns + 2.5ns) / 1ps));
        end
      end else begin
        // R6
        chk(dst_data == last_data, "R6 hold between transfers", dst_data, last_data);
      end
      last_data  = dst_data;
      prev_valid = dst_valid;
    end
  end

  initial begin
    #(500us);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int idle_valid;
    repeat (4) @(negedge dst_clk);
    // R1: during reset
    chk(dst_valid == 1'b0, "R1 valid in reset", {31'b0, dst_valid}, '0);
    chk(dst_data == '0, "R1 data in reset", dst_data, '0);
    src_rst_n = 1'b1;
    dst_rst_n = 1'b1;
    // R8: long idle, bus wiggling without strobe
    idle_valid = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge dst_clk);
      src_data = DATA_W'($urandom);
      if (dst_valid) idle_valid++;
    end
    chk(idle_valid == 0, "R8 no load while idle", DATA_W'(idle_valid), '0);
    // R1: after release
    chk(dst_data == '0, "R1 data after reset", dst_data, '0);
    mon_on = 1'b1;

    // R4: directed patterns
    send('0, 8);
    send('1, 8);
    send({(DATA_W/2){2'b01}}, 8);
    send({(DATA_W/2){2'b10}}, 8);
    send(DATA_W'(1), 8);
    send({1'b1, {(DATA_W-1){1'b0}}}, 8);
    // R3 / R5: random words at random legal spacing
    for (int n = 0; n < 60; n++) send(DATA_W'($urandom), 6 + int'($urandom_range(0, 10)));

    repeat (40) @(negedge dst_clk);
    // R2: every word delivered exactly once
    chk(got == sent, "R2 delivered count", DATA_W'(got), DATA_W'(sent));
    chk(exp_q.size() == 0, "R2 nothing left pending", DATA_W'(exp_q.size()), '0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule